// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block decides which of five requesters, called localities, owns a shared device at any moment. Each locality reaches its own 8-bit access register through a write port. The locality number is taken from address bits 14:12. Writes carry request, release, seize and flag-clear bits. The block keeps one request flag and one seized-history flag per locality, plus the current owner. From these it builds the read-back value of every access register.

Ownership moves in one of three ways. A request is granted when nobody owns the device. A release by the owner hands the device to the highest-numbered waiting requester. A seize is open only to a locality numbered above the current owner. Every hand-over that pre-empts a running owner raises a one-cycle abort request toward the command controller. Every move to a new owner raises a one-cycle locality-changed event. Locality 4 is reserved for hardware: its writes count only when they carry the hardware-origin flag.

Top module: `loc_arbiter`

## Requirements
- R1: After reset no locality owns the device, both event outputs are low, and every access register reads 0x80 with bit 0 equal to `estab_i`.
- R2: A request-use write (bit 1) when no locality owns the device makes the writer the owner and pulses `loc_changed_o` for one cycle, without an abort.
- R3: A request-use write from a non-owner while another locality owns the device sets the writer's request flag (read at bit 1), and ownership stays unchanged. The same write from the owner has no effect, and the owner's request flag always reads 0.
- R4: Bit 2 of a locality's access register reads 1 exactly when some other locality has its request flag set.
- R5: A release write (bit 5) from the owner while requesters wait makes the highest-numbered requester the owner. Its request flag is cleared, and both `abort_req_o` and `loc_changed_o` pulse for one cycle.
- R6: A release write from the owner with no requesters waiting leaves the device without owner, and neither event output pulses.
- R7: A release write from a non-owner clears its own request flag. A write with bit 5 set ignores its bit 1.
- R8: A seize write (bit 3) is accepted when no locality owns the device or the writer's number is above the owner's. The writer becomes owner in that cycle, its request flag is cleared, and both events pulse. The previous owner gets its seized flag (bit 4) set and keeps its request flag. A write with bit 3 set ignores its bits 1 and 5.
- R9: A seize write from a locality numbered at or below the current owner changes nothing.
- R10: Bit 7 of every access register always reads 1, bit 6 and bit 3 always read 0, and bit 5 reads 1 only for the owner.
- R11: A write with bit 4 set clears the writer's own seized flag.
- R12: Writes are dropped when they come from locality 4 without `hw_origin_i`, when they target locality 5 to 7, or when address bits 11:0 are not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wr_addr_i | input | 15 | Write address; bits 14:12 select the locality |
| wr_data_i | input | 8 | Write data for the access register |
| hw_origin_i | input | 1 | Write comes from hardware (needed for locality 4) |
| estab_i | input | 1 | Value shown at bit 0 of every access register |
| owner_valid_o | output | 1 | Some locality owns the device |
| owner_o | output | 3 | Number of the owning locality |
| loc_changed_o | output | 1 | One-cycle pulse when ownership moves to a locality |
| abort_req_o | output | 1 | One-cycle pulse asking the command controller to abort |
| acc_rd_o | output | 40 | Read-back access registers, locality n at bits 8n+7:8n |

## Verification
A write sampled at a rising edge updates the owner, the flags and both event pulses at that same edge. Every result is therefore due one edge after the write, and each pulse lasts exactly that one cycle. The bench drives inputs on the falling edge and holds the strobe for one cycle. It compares all five registers, the owner and both pulses at the following falling edge. An idle cycle sits between writes, so a pulse that lasts more than one cycle cannot go unnoticed.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
    // Access register bit positions; software decodes these, so they are fixed.
    localparam int BIT_REGVALID = 7;
    localparam int BIT_ACTIVE   = 5;
    localparam int BIT_SEIZED   = 4;
    localparam int BIT_SEIZE    = 3;
    localparam int BIT_PENDING  = 2;
    localparam int BIT_REQUEST  = 1;
    localparam int BIT_ESTAB    = 0;
    localparam int REG_W        = 8;

    typedef struct packed {
        logic request;
        logic release_own;
        logic seize;
        logic clr_seized;
    } wr_cmd_t;
endpackage

// File: rtl/loc_arb_decode.sv
module loc_arb_decode
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_LSB = 12,
    parameter int LOC_W   = 3,
    parameter int HW_LOC  = 4
) (
    input  logic                     wr_en_i,
    input  logic [LOC_LSB+LOC_W-1:0] wr_addr_i,
    input  logic [REG_W-1:0]         wr_data_i,
    input  logic                     hw_origin_i,
    output logic                     hit_o,
    output logic [LOC_W-1:0]         loc_o,
    output wr_cmd_t                  cmd_o
);
    logic [LOC_W-1:0] loc;
    logic             in_range;
    logic             hw_ok;
    logic             unused_data;

    assign loc      = wr_addr_i[LOC_LSB+LOC_W-1:LOC_LSB];
    assign in_range = (32'(loc) < NUM_LOC);
    assign hw_ok    = (32'(loc) != HW_LOC) || hw_origin_i;
    assign hit_o    = wr_en_i && in_range && hw_ok
                      && (wr_addr_i[LOC_LSB-1:0] == '0);
    assign loc_o    = loc;

    assign cmd_o.request     = wr_data_i[BIT_REQUEST];
    assign cmd_o.release_own = wr_data_i[BIT_ACTIVE];
    assign cmd_o.seize       = wr_data_i[BIT_SEIZE];
    assign cmd_o.clr_seized  = wr_data_i[BIT_SEIZED];
    assign unused_data = ^{wr_data_i[BIT_REGVALID], wr_data_i[6],
                           wr_data_i[BIT_PENDING], wr_data_i[BIT_ESTAB]};
endmodule

// File: rtl/loc_arb_pick.sv
module loc_arb_pick #(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3
) (
    input  logic [NUM_LOC-1:0] req_i,
    output logic               vld_o,
    output logic [LOC_W-1:0]   idx_o
);
    // Highest-numbered set bit wins.
    always_comb begin
        vld_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (req_i[i]) begin
                vld_o = 1'b1;
                idx_o = LOC_W'(i);
            end
        end
    end
endmodule

// File: rtl/loc_arb_readback.sv
module loc_arb_readback
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3
) (
    input  logic                     owner_vld_i,
    input  logic [LOC_W-1:0]         owner_i,
    input  logic [NUM_LOC-1:0]       req_i,
    input  logic [NUM_LOC-1:0]       seized_i,
    input  logic                     estab_i,
    output logic [NUM_LOC*REG_W-1:0] acc_o
);
    for (genvar g = 0; g < NUM_LOC; g++) begin : g_reg
        logic [NUM_LOC-1:0] others;
        logic [REG_W-1:0]   val;
        always_comb begin
            others               = req_i;
            others[g]            = 1'b0;
            val                  = '0;
            val[BIT_REGVALID]    = 1'b1;
            val[BIT_ACTIVE]      = owner_vld_i && (owner_i == LOC_W'(g));
            val[BIT_SEIZED]      = seized_i[g];
            val[BIT_SEIZE]       = 1'b0;
            val[BIT_PENDING]     = |others;
            val[BIT_REQUEST]     = req_i[g];
            val[BIT_ESTAB]       = estab_i;
        end
        assign acc_o[g*REG_W +: REG_W] = val;
    end
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_LSB = 12,
    localparam int LOC_W  = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1,
    localparam int ADDR_W = LOC_LSB + LOC_W,
    localparam int HW_LOC = NUM_LOC - 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        wr_addr_i,
    input  logic [REG_W-1:0]         wr_data_i,
    input  logic                     hw_origin_i,
    input  logic                     estab_i,
    output logic                     owner_valid_o,
    output logic [LOC_W-1:0]         owner_o,
    output logic                     loc_changed_o,
    output logic                     abort_req_o,
    output logic [NUM_LOC*REG_W-1:0] acc_rd_o
);
    typedef struct packed {
        logic               vld;
        logic [LOC_W-1:0]   owner;
        logic [NUM_LOC-1:0] req;
        logic [NUM_LOC-1:0] seized;
        logic               chg;
        logic               abort;
    } arb_state_t;

    arb_state_t       st_d, st_q;
    logic             hit;
    logic [LOC_W-1:0] wr_loc;
    wr_cmd_t          cmd;
    logic             pick_vld;
    logic [LOC_W-1:0] pick_idx;

    loc_arb_decode #(
        .NUM_LOC(NUM_LOC), .LOC_LSB(LOC_LSB), .LOC_W(LOC_W), .HW_LOC(HW_LOC)
    ) u_decode (
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .hw_origin_i(hw_origin_i),
        .hit_o      (hit),
        .loc_o      (wr_loc),
        .cmd_o      (cmd)
    );

    loc_arb_pick #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_pick (
        .req_i(st_q.req),
        .vld_o(pick_vld),
        .idx_o(pick_idx)
    );

    always_comb begin
        logic is_owner;
        st_d       = st_q;
        st_d.chg   = 1'b0;
        st_d.abort = 1'b0;
        is_owner   = st_q.vld && (st_q.owner == wr_loc);
        if (hit) begin
            if (cmd.clr_seized) begin
                st_d.seized[wr_loc] = 1'b0;
            end
            if (cmd.seize) begin
                if (!st_q.vld || (wr_loc > st_q.owner)) begin
                    if (st_q.vld) begin
                        st_d.seized[st_q.owner] = 1'b1;
                    end
                    st_d.req[wr_loc] = 1'b0;
                    st_d.vld         = 1'b1;
                    st_d.owner       = wr_loc;
                    st_d.chg         = 1'b1;
                    st_d.abort       = 1'b1;
                end
            end else if (cmd.release_own) begin
                st_d.req[wr_loc] = 1'b0;
                if (is_owner) begin
                    if (pick_vld) begin
                        st_d.owner         = pick_idx;
                        st_d.req[pick_idx] = 1'b0;
                        st_d.chg           = 1'b1;
                        st_d.abort         = 1'b1;
                    end else begin
                        st_d.vld = 1'b0;
                    end
                end
            end else if (cmd.request) begin
                if (!st_q.vld) begin
                    st_d.vld   = 1'b1;
                    st_d.owner = wr_loc;
                    st_d.chg   = 1'b1;
                end else if (!is_owner) begin
                    st_d.req[wr_loc] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    loc_arb_readback #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_readback (
        .owner_vld_i(st_q.vld),
        .owner_i    (st_q.owner),
        .req_i      (st_q.req),
        .seized_i   (st_q.seized),
        .estab_i    (estab_i),
        .acc_o      (acc_rd_o)
    );

    assign owner_valid_o = st_q.vld;
    assign owner_o       = st_q.owner;
    assign loc_changed_o = st_q.chg;
    assign abort_req_o   = st_q.abort;

    logic [NUM_LOC-1:0] active_bits;
    for (genvar g = 0; g < NUM_LOC; g++) begin : g_act
        assign active_bits[g] = acc_rd_o[g*REG_W + BIT_ACTIVE];
    end

    AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(active_bits) == (owner_valid_o ? 1 : 0)); // R10
    AST_RISE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(owner_valid_o) |-> loc_changed_o); // R2
    AST_ABORT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req_o |-> loc_changed_o && owner_valid_o); // R5
    AST_OWNER_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        owner_valid_o |-> !acc_rd_o[32'(owner_o)*REG_W + BIT_REQUEST]); // R3
    AST_HW_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && (32'(wr_addr_i[ADDR_W-1:LOC_LSB]) == HW_LOC) && !hw_origin_i
        |=> $stable(owner_o) && $stable(owner_valid_o) && !loc_changed_o); // R12
    AST_SEIZE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req_o && $past(owner_valid_o) && $past(wr_data_i[BIT_SEIZE])
        |-> owner_o > $past(owner_o)); // R8
endmodule

// File: tb/loc_arbiter_test.sv
module loc_arbiter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [14:0] wr_addr_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic        hw_origin_i = 1'b0;
    logic        estab_i = 1'b0;
    logic        owner_valid_o;
    logic [2:0]  owner_o;
    logic        loc_changed_o;
    logic        abort_req_o;
    logic [39:0] acc_rd_o;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    loc_arbiter uut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .hw_origin_i(hw_origin_i), .estab_i(estab_i),
        .owner_valid_o(owner_valid_o), .owner_o(owner_o),
        .loc_changed_o(loc_changed_o), .abort_req_o(abort_req_o),
        .acc_rd_o(acc_rd_o)
    );

    // Reference state
    logic [4:0] m_req = '0;
    logic [4:0] m_sz  = '0;
    logic       m_vld = 1'b0;
    int         m_own = 0;
    logic       m_chg = 1'b0;
    logic       m_abt = 1'b0;
    string      m_tag = "R1";

    task automatic check(input logic ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        for (int i = 0; i < 5; i++) begin
            logic [7:0] e;
            logic [4:0] oth;
            oth = m_req;
            oth[i] = 1'b0;
            e = {1'b1, 1'b0, (m_vld && m_own == i), m_sz[i], 1'b0,
                 |oth, m_req[i], estab_i};
            check(acc_rd_o[i*8 +: 8] == e,
                  (m_tag == "R1") ? "R1" : ((|oth != 0) ? "R4" : "R10"),
                  $sformatf("%s acc[%0d]", m_tag, i), acc_rd_o[i*8 +: 8], e);
        end
        check(owner_valid_o == m_vld, m_tag, "owner_valid", owner_valid_o, m_vld);
        if (m_vld)
            check(owner_o == 3'(m_own), m_tag, "owner", owner_o, m_own);
        check(loc_changed_o == m_chg, m_tag, "loc_changed", loc_changed_o, m_chg);
        check(abort_req_o == m_abt, m_tag, "abort_req", abort_req_o, m_abt);
    endtask

    task automatic model(input int loc, input logic [7:0] d, input logic hw,
                         input logic [11:0] off);
        logic own;
        m_chg = 1'b0;
        m_abt = 1'b0;
        if (loc > 4 || off != 0 || (loc == 4 && !hw)) begin
            m_tag = "R12";
            return;
        end
        own = m_vld && m_own == loc;
        m_tag = "R10";
        if (d[4]) begin
            m_sz[loc] = 1'b0;
            m_tag = "R11";
        end
        if (d[3]) begin
            if (!m_vld || loc > m_own) begin
                if (m_vld) m_sz[m_own] = 1'b1;
                m_req[loc] = 1'b0;
                m_vld = 1'b1;
                m_own = loc;
                m_chg = 1'b1;
                m_abt = 1'b1;
                m_tag = "R8";
            end else begin
                m_tag = "R9";
            end
        end else if (d[5]) begin
            m_req[loc] = 1'b0;
            if (own) begin
                int best;
                best = -1;
                for (int i = 0; i < 5; i++) if (m_req[i]) best = i;
                if (best >= 0) begin
                    m_own = best;
                    m_req[best] = 1'b0;
                    m_chg = 1'b1;
                    m_abt = 1'b1;
                    m_tag = "R5";
                end else begin
                    m_vld = 1'b0;
                    m_tag = "R6";
                end
            end else begin
                m_tag = "R7";
            end
        end else if (d[1]) begin
            if (!m_vld) begin
                m_vld = 1'b1;
                m_own = loc;
                m_chg = 1'b1;
                m_tag = "R2";
            end else begin
                if (!own) m_req[loc] = 1'b1;
                m_tag = "R3";
            end
        end
    endtask

    task automatic do_write(input int loc, input logic [7:0] d, input logic hw,
                            input logic [11:0] off);
        @(negedge clk);
        wr_en_i     = 1'b1;
        wr_addr_i   = {3'(loc), off};
        wr_data_i   = d;
        hw_origin_i = hw;
        @(negedge clk);
        wr_en_i = 1'b0;
        model(loc, d, hw, off);
        check_all();
        @(negedge clk);
        m_chg = 1'b0;
        m_abt = 1'b0;
        check(loc_changed_o == 1'b0 && abort_req_o == 1'b0, m_tag,
              "pulse length", {loc_changed_o, abort_req_o}, 0);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_tag = "R1";
        check_all();
        estab_i = 1'b1;
        #1 check_all();

        do_write(1, 8'h02, 1'b0, 12'h0); // R2 grant to idle device
        do_write(3, 8'h02, 1'b0, 12'h0); // R3 queue request, R4 pending
        do_write(0, 8'h02, 1'b0, 12'h0); // R3
        do_write(1, 8'h02, 1'b0, 12'h0); // R3 owner request no effect
        do_write(4, 8'h02, 1'b0, 12'h0); // R12 no hw flag
        do_write(3, 8'h02, 1'b0, 12'h4); // R12 other offset
        do_write(0, 8'h22, 1'b0, 12'h0); // R7 release by non-owner
        do_write(1, 8'h20, 1'b0, 12'h0); // R5 handover to 3
        do_write(2, 8'h08, 1'b0, 12'h0); // R9 lower seize refused
        do_write(3, 8'h08, 1'b0, 12'h0); // R9 owner seize refused
        do_write(2, 8'h02, 1'b0, 12'h0); // R3 queue
        do_write(4, 8'h08, 1'b1, 12'h0); // R8 seize by hw locality
        do_write(3, 8'h10, 1'b0, 12'h0); // R11 clear seized
        do_write(4, 8'h20, 1'b1, 12'h0); // R5 handover to 2
        do_write(2, 8'h20, 1'b0, 12'h0); // R6 release, nobody waits
        do_write(0, 8'h0A, 1'b0, 12'h0); // R8 seize with no owner

        lf = 32'h1234_5678;
        for (int n = 0; n < 4000; n++) begin
            int loc;
            logic [7:0] d;
            logic [11:0] off;
            lf = lf ^ (lf << 13);
            lf = lf ^ (lf >> 17);
            lf = lf ^ (lf << 5);
            loc = (lf[3:0] < 4'd13) ? int'(lf[6:4]) % 5 : int'(lf[6:4]);
            d   = {lf[15:14], lf[9:8] == 2'b00, lf[10] & lf[11], lf[12] & lf[13] & lf[9],
                   lf[16], lf[17] | lf[18], lf[19]};
            off = (lf[22:20] == 3'b000) ? 12'(lf[31:24]) | 12'h1 : 12'h0;
            estab_i = lf[23];
            do_write(loc, d, lf[21] | lf[22], off);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule